// File: doc/BRIEF.md
# Multichannel ADC Capture Buffer

This block collects conversion frames from a simultaneous-sampling multichannel delta-sigma converter. The converter's serial port is read-only. The block generates the serial clock itself and waits for the converter's active-low data-ready line to fall. It then clocks in one word per channel and stores every sample in a byte-wide external asynchronous SRAM. The SRAM is used as a circular buffer, so acquisition keeps running in real time while a host computer drains the stored bytes at its own pace.

Each sample becomes a group of consecutive bytes, most significant byte first, and the channels are stored in ascending order. The write pointer wraps around at the end of the memory. A frame that would overrun bytes the host has not read yet is discarded whole, and a sticky overflow flag records the loss. The host sees the number of unread bytes at all times. It fetches bytes one at a time through a request/valid read port, and the block schedules those reads on the shared SRAM between its own writes. A small control input also drives one power-down line per converter channel.

Top module: `adc_sram_capture`

## Requirements
- R1: During and right after reset: `fill` = 0, `overflow` = 0, `sram_we_n` = 1, `sram_oe_n` = 1, `adc_sclk` = 0, `rd_valid` = 0, and every bit of `adc_pwdn_n` = 1.
- R2: A frame starts only on a falling edge of `adc_drdy_n`, seen after a two-flop synchroniser. `adc_sclk` idles low. Each frame has exactly NCH*SW rising edges of `adc_sclk`. Every high phase and every low phase lasts at least SCLK_HALF system cycles. A falling edge of `adc_drdy_n` while a frame is being shifted is ignored.
- R3: Serial bits are taken most significant bit first. The first bit of a frame is the top bit of channel 0.
- R4: Each sample is written as SW/8 bytes, most significant byte first. Channels go in order 0 to NCH-1, and the bytes go to consecutive SRAM addresses.
- R5: Each SRAM write holds `sram_we_n` low for at least ceil(ACCESS_PS/CLK_PERIOD_PS) cycles. `sram_addr` and `sram_dq_o` stay stable while it is low and in the cycle it rises. `sram_dq_oe` is 1 while it is low. `sram_we_n` and `sram_oe_n` are never low together.
- R6: The write address goes from 2^AW-1 back to 0.
- R7: `fill` equals bytes written minus bytes read. It changes by at most one per cycle and never exceeds 2^AW.
- R8: A frame is stored only if 2^AW - `fill` is at least NCH*SW/8. Otherwise the whole frame is dropped, stored data is left untouched, and `overflow` becomes 1 and stays 1 until reset.
- R9: A one-cycle `rd_req` with `fill` > 0 reads the oldest unread byte. `rd_valid` then pulses for one cycle with that byte on `rd_data`, and `fill` drops by one. A `rd_req` with `fill` = 0 is ignored.
- R10: A cycle with `cfg_we` = 1 loads `cfg_chan_en`, and `adc_pwdn_n` shows it on the next cycle (1 = channel running). While `cfg_we` = 0, `adc_pwdn_n` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| adc_dout | input | 1 | Converter serial data |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_pwdn_n | output | NCH | Per-channel power-down, 0 = off |
| cfg_we | input | 1 | Load strobe for channel enables |
| cfg_chan_en | input | NCH | Channel enable pattern |
| sram_addr | output | AW | SRAM address |
| sram_dq_o | output | 8 | SRAM write data |
| sram_dq_oe | output | 1 | Drive enable for SRAM data pins |
| sram_dq_i | input | 8 | SRAM read data |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| rd_req | input | 1 | Host request for one byte |
| rd_valid | output | 1 | Read byte valid pulse |
| rd_data | output | 8 | Read byte |
| fill | output | AW+1 | Unread byte count |
| overflow | output | 1 | Sticky frame-drop flag |

## Verification
The hardest case to reach is a frame arriving when the buffer is completely full, because the loss has to be observed together with the pointer wrap-around. The bench uses a 32-byte memory and two 16-bit channels, so eight frames fill the buffer exactly and the ninth must be dropped. It then drains the whole buffer, refills it so the write address crosses the top of memory, and drains it again, comparing every byte with values computed from the frame number. A second data-ready pulse is injected in the middle of one frame to show that it is ignored.

// File: rtl/adc_sram_capture.sv
package adc_cap_pkg;
  typedef enum logic [2:0] {P_IDLE, P_WSET, P_WPUL, P_WHLD, P_RD} port_st_t;
endpackage

module adc_drdy_sync (
  input  logic clk,
  input  logic rst,
  input  logic drdy_n,
  output logic start
);
  logic [2:0] sr;
  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= 3'b111;
      start <= 1'b0;
    end else begin
      sr    <= {sr[1:0], drdy_n};
      start <= sr[2] & ~sr[1];
    end
  end
endmodule

module adc_spi_rx #(
  parameter int NB   = 192,
  parameter int HALF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dout,
  output logic          sclk,
  output logic          frame_vld,
  output logic [NB-1:0] frame
);
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = $clog2(NB + 1);
  logic          run;
  logic [DW-1:0] div;
  logic [BW-1:0] nbit;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; div <= '0; nbit <= '0;
      sclk <= 1'b0; frame_vld <= 1'b0; frame <= '0;
    end else begin
      frame_vld <= 1'b0;
      if (!run) begin
        if (start) begin
          run  <= 1'b1;
          div  <= '0;
          nbit <= '0;
        end
      end else if (div == DW'(HALF - 1)) begin
        div <= '0;
        if (!sclk) sclk <= 1'b1;
        else begin
          sclk  <= 1'b0;
          frame <= {frame[NB-2:0], dout};
          nbit  <= nbit + 1'b1;
          if (nbit == BW'(NB - 1)) begin
            run       <= 1'b0;
            frame_vld <= 1'b1;
          end
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end
endmodule

module adc_sram_port #(
  parameter int AW  = 22,
  parameter int ACC = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_go,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  output logic          idle,
  output logic          rd_done,
  output logic [7:0]    rd_data,
  output logic [AW-1:0] sram_addr,
  output logic [7:0]    sram_dq_o,
  output logic          sram_dq_oe,
  input  logic [7:0]    sram_dq_i,
  output logic          sram_we_n,
  output logic          sram_oe_n
);
  import adc_cap_pkg::*;
  localparam int CW = $clog2(ACC + 1);
  port_st_t      st;
  logic [CW-1:0] cnt;

  assign idle = (st == P_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= P_IDLE; cnt <= '0; sram_addr <= '0; sram_dq_o <= '0;
      sram_dq_oe <= 1'b0; sram_we_n <= 1'b1; sram_oe_n <= 1'b1;
      rd_done <= 1'b0; rd_data <= '0;
    end else begin
      rd_done <= 1'b0;
      case (st)
        P_IDLE: begin
          if (wr_go) begin
            sram_addr  <= wr_addr;
            sram_dq_o  <= wr_data;
            sram_dq_oe <= 1'b1;
            st         <= P_WSET;
          end else if (rd_go) begin
            sram_addr <= rd_addr;
            sram_oe_n <= 1'b0;
            cnt       <= '0;
            st        <= P_RD;
          end
        end
        P_WSET: begin
          sram_we_n <= 1'b0;
          cnt       <= '0;
          st        <= P_WPUL;
        end
        P_WPUL: begin
          if (cnt == CW'(ACC - 1)) begin
            sram_we_n <= 1'b1;
            st        <= P_WHLD;
          end else cnt <= cnt + 1'b1;
        end
        P_WHLD: begin
          sram_dq_oe <= 1'b0;
          st         <= P_IDLE;
        end
        P_RD: begin
          if (cnt == CW'(ACC - 1)) begin
            rd_data   <= sram_dq_i;
            sram_oe_n <= 1'b1;
            rd_done   <= 1'b1;
            st        <= P_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= P_IDLE;
      endcase
    end
  end
endmodule

module adc_sram_capture #(
  parameter int NCH           = 8,
  parameter int SW            = 24,
  parameter int AW            = 22,
  parameter int SCLK_HALF     = 5,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int ACCESS_PS     = 55000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adc_drdy_n,
  input  logic           adc_dout,
  output logic           adc_sclk,
  output logic [NCH-1:0] adc_pwdn_n,
  input  logic           cfg_we,
  input  logic [NCH-1:0] cfg_chan_en,
  output logic [AW-1:0]  sram_addr,
  output logic [7:0]     sram_dq_o,
  output logic           sram_dq_oe,
  input  logic [7:0]     sram_dq_i,
  output logic           sram_we_n,
  output logic           sram_oe_n,
  input  logic           rd_req,
  output logic           rd_valid,
  output logic [7:0]     rd_data,
  output logic [AW:0]    fill,
  output logic           overflow
);
  localparam int NB      = NCH * SW;
  localparam int FB      = NCH * (SW / 8);
  localparam int LW      = $clog2(FB + 1);
  localparam int ACC_RAW = (ACCESS_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int ACC_CYC = (ACC_RAW < 1) ? 1 : ACC_RAW;
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] FB_V    = (AW+1)'(FB);

  logic          start, frame_vld, idle, wr_go, rd_go, rd_pend;
  logic [NB-1:0] frame, pend;
  logic [LW-1:0] left;
  logic [AW-1:0] wp, rp;
  logic [AW:0]   occ, free_b;
  logic          room;

  adc_drdy_sync u_sync (.clk(clk), .rst(rst), .drdy_n(adc_drdy_n), .start(start));

  adc_spi_rx #(.NB(NB), .HALF(SCLK_HALF)) u_rx (
    .clk(clk), .rst(rst), .start(start), .dout(adc_dout),
    .sclk(adc_sclk), .frame_vld(frame_vld), .frame(frame));

  assign wr_go  = idle && (left != '0);
  assign rd_go  = idle && !wr_go && rd_pend;
  assign free_b = DEPTH_V - occ;
  assign room   = (left == '0) && (free_b >= FB_V);

  adc_sram_port #(.AW(AW), .ACC(ACC_CYC)) u_port (
    .clk(clk), .rst(rst),
    .wr_go(wr_go), .wr_addr(wp), .wr_data(pend[NB-1 -: 8]),
    .rd_go(rd_go), .rd_addr(rp), .idle(idle),
    .rd_done(rd_valid), .rd_data(rd_data),
    .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_dq_i(sram_dq_i), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0; left <= '0; wp <= '0; rp <= '0; occ <= '0;
      rd_pend <= 1'b0; overflow <= 1'b0;
    end else begin
      if (wr_go) begin
        pend <= pend << 8;
        left <= left - 1'b1;
        wp   <= wp + 1'b1;
      end
      if (frame_vld && room) begin
        pend <= frame;
        left <= LW'(FB);
      end
      if (frame_vld && !room) overflow <= 1'b1;
      if (wr_go)      occ <= occ + 1'b1;
      else if (rd_go) occ <= occ - 1'b1;
      if (rd_go) begin
        rp      <= rp + 1'b1;
        rd_pend <= 1'b0;
      end else if (rd_req && occ != '0) begin
        rd_pend <= 1'b1;
      end
    end
  end

  assign fill = occ;

  always_ff @(posedge clk) begin
    if (rst)         adc_pwdn_n <= '1;
    else if (cfg_we) adc_pwdn_n <= cfg_chan_en;
  end
endmodule

module adc_sram_capture_chk #(
  parameter int NCH  = 8,
  parameter int AW   = 22,
  parameter int HALF = 5,
  parameter int ACC  = 14
) (
  input logic           clk,
  input logic           rst,
  input logic           adc_sclk,
  input logic [NCH-1:0] adc_pwdn_n,
  input logic           cfg_we,
  input logic [NCH-1:0] cfg_chan_en,
  input logic [AW-1:0]  sram_addr,
  input logic [7:0]     sram_dq_o,
  input logic           sram_dq_oe,
  input logic           sram_we_n,
  input logic           sram_oe_n,
  input logic [AW:0]    fill,
  input logic           overflow
);
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};
  logic [15:0] we_lo, sc_hi, sc_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo <= '0; sc_hi <= '0; sc_lo <= '0;
    end else begin
      we_lo <= sram_we_n ? 16'd0 : ((we_lo == 16'hFFFF) ? we_lo : we_lo + 1'b1);
      sc_hi <= !adc_sclk ? 16'd0 : ((sc_hi == 16'hFFFF) ? sc_hi : sc_hi + 1'b1);
      sc_lo <= adc_sclk  ? 16'd0 : ((sc_lo == 16'hFFFF) ? sc_lo : sc_lo + 1'b1);
    end
  end

  a_r5_we_width: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> we_lo >= 16'(ACC));
  a_r5_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n || $rose(sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_o)));
  a_r5_dq_driven: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> sram_dq_oe);
  a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
    !(!sram_we_n && !sram_oe_n));
  a_r2_sclk_high: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_sclk) |-> sc_hi >= 16'(HALF));
  a_r2_sclk_low: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_sclk) |-> sc_lo >= 16'(HALF));
  a_r7_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill <= DEPTH_V);
  a_r7_fill_step: assert property (@(posedge clk) disable iff (rst)
    (fill == $past(fill)) || (fill == $past(fill) + 1'b1) || (fill == $past(fill) - 1'b1));
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  a_r10_pwdn_load: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_we) && !$past(rst)) |-> adc_pwdn_n == $past(cfg_chan_en));
endmodule

bind adc_sram_capture adc_sram_capture_chk #(
  .NCH(NCH), .AW(AW), .HALF(SCLK_HALF), .ACC(ACC_CYC)
) u_chk (
  .clk(clk), .rst(rst), .adc_sclk(adc_sclk), .adc_pwdn_n(adc_pwdn_n),
  .cfg_we(cfg_we), .cfg_chan_en(cfg_chan_en), .sram_addr(sram_addr),
  .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_we_n(sram_we_n),
  .sram_oe_n(sram_oe_n), .fill(fill), .overflow(overflow));

// File: tb/adc_sram_capture_test.sv
`timescale 1ns/1ps
module adc_sram_capture_test;
  localparam int NCH = 2, SW = 16, AW = 5, HALF = 2;
  localparam int CP = 4000, APS = 10000, ACC = 3;
  localparam int NB = NCH * SW, BPS = SW / 8, FB = NCH * BPS, DEPTH = 1 << AW;

  logic clk = 0, rst = 1;
  logic drdy_n = 1, dout = 0, cfg_we = 0, rd_req = 0;
  logic [NCH-1:0] cfg_en = '1;
  logic adc_sclk, sram_dq_oe, sram_we_n, sram_oe_n, rd_valid, overflow;
  logic [NCH-1:0] pwdn;
  logic [AW-1:0] sram_addr;
  logic [7:0] sram_dq_o, sram_dq_i, rd_data;
  logic [AW:0] fill;
  logic [7:0] mem [0:DEPTH-1];

  always #2 clk = ~clk;

  adc_sram_capture #(.NCH(NCH), .SW(SW), .AW(AW), .SCLK_HALF(HALF),
    .CLK_PERIOD_PS(CP), .ACCESS_PS(APS)) uut (
    .clk(clk), .rst(rst), .adc_drdy_n(drdy_n), .adc_dout(dout),
    .adc_sclk(adc_sclk), .adc_pwdn_n(pwdn), .cfg_we(cfg_we),
    .cfg_chan_en(cfg_en), .sram_addr(sram_addr), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data), .fill(fill), .overflow(overflow));

  assign sram_dq_i = mem[sram_addr];

  int n_chk = 0, n_fail = 0;
  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [SW-1:0] samp(int k, int c);
    return SW'((k * 933 + c * 499 + 193) ^ (k << 9));
  endfunction
  function automatic logic [NB-1:0] fbits(int k);
    logic [NB-1:0] r;
    for (int c = 0; c < NCH; c++) r[NB-1-c*SW -: SW] = samp(k, c);
    return r;
  endfunction
  function automatic int exp_byte(int k, int b);
    logic [SW-1:0] s;
    s = samp(k, b / BPS);
    return int'(8'(s >> (8 * (BPS - 1 - (b % BPS)))));
  endfunction

  // converter model: bit 0 ready at data-ready, next bit after each falling sclk
  logic [NB-1:0] cur = '0;
  int bidx = 0, rises = 0;
  always @(negedge adc_sclk) begin
    bidx++;
    if (bidx < NB) dout = cur[NB-1-bidx];
  end
  always @(posedge adc_sclk) rises++;

  // monitors: phase widths, write addresses, SRAM model
  int sc_run = 0, we_run = 0, sclk_viol = 0, we_viol = 0, wa_bad = 0, n_wr = 0, exp_wa = 0;
  logic sc_prev = 0, we_prev = 1;
  always @(negedge clk) if (!rst) begin
    if (adc_sclk == sc_prev) sc_run++;
    else begin
      if (sc_run < HALF) sclk_viol++;
      sc_run = 1; sc_prev = adc_sclk;
    end
    if (sram_we_n == we_prev) we_run++;
    else begin
      if (!we_prev && we_run < ACC) we_viol++;
      we_run = 1; we_prev = sram_we_n;
    end
  end
  always @(posedge sram_we_n) if (!rst) begin
    mem[sram_addr] = sram_dq_o;
    if (int'(sram_addr) != exp_wa) wa_bad++;
    exp_wa = (exp_wa + 1) % DEPTH;
    n_wr++;
  end

  task automatic send_frame(int k, bit glitch);
    cur = fbits(k); bidx = 0; dout = cur[NB-1]; rises = 0;
    @(negedge clk) drdy_n = 0;
    repeat (4) @(negedge clk);
    drdy_n = 1;
    if (glitch) begin
      repeat (40) @(negedge clk);
      drdy_n = 0;
      repeat (4) @(negedge clk);
      drdy_n = 1;
    end
    for (int t = 0; t < 5000 && rises < NB; t++) @(negedge clk);
    repeat (80) @(negedge clk);
  endtask

  task automatic read_byte(output int d, output bit got);
    got = 0; d = -1;
    @(negedge clk) rd_req = 1;
    @(negedge clk) rd_req = 0;
    for (int t = 0; t < 40 && !got; t++) begin
      if (rd_valid) begin got = 1; d = int'(rd_data); end
      else @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 150000 cycles expected earlier completion");
    finish_up();
  end

  initial begin
    int d;
    bit got;
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 fill", int'(fill), 0);
    check("R1 overflow", int'(overflow), 0);
    check("R1 we_n", int'(sram_we_n), 1);
    check("R1 oe_n", int'(sram_oe_n), 1);
    check("R1 sclk", int'(adc_sclk), 0);
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 pwdn", int'(pwdn), (1 << NCH) - 1);

    // R10 every enable pattern, then a value without strobe
    for (int p = 0; p < (1 << NCH); p++) begin
      @(negedge clk) begin cfg_en = NCH'(p); cfg_we = 1; end
      @(negedge clk) cfg_we = 0;
      check("R10 pwdn load", int'(pwdn), p);
    end
    @(negedge clk) cfg_en = '0;
    repeat (3) @(negedge clk);
    check("R10 pwdn hold", int'(pwdn), (1 << NCH) - 1);

    // R9 read from empty buffer is ignored
    read_byte(d, got);
    check("R9 empty read no valid", int'(got), 0);
    check("R9 empty fill", int'(fill), 0);

    // single frame, then read back
    send_frame(0, 0);
    check("R2 sclk rises per frame", rises, NB);
    check("R7 fill after frame", int'(fill), FB);
    for (int b = 0; b < FB; b++) begin
      read_byte(d, got);
      check("R9 read valid", int'(got), 1);
      if (b == 0) check("R3 first byte ch0 msb", d, exp_byte(0, b));
      else        check("R4 byte order", d, exp_byte(0, b));
    end
    check("R9 fill after drain", int'(fill), 0);

    // fill to capacity; frame 3 carries a mid-frame data-ready edge
    for (int k = 1; k <= DEPTH / FB; k++) begin
      send_frame(k, k == 3);
      check("R7 fill step", int'(fill), FB * k);
      if (k == 3) check("R2 mid-frame edge ignored", rises, NB);
    end
    check("R8 no overflow at exact full", int'(overflow), 0);

    send_frame(99, 0);
    check("R8 overflow set", int'(overflow), 1);
    check("R8 fill unchanged", int'(fill), DEPTH);

    for (int i = 0; i < DEPTH; i++) begin
      read_byte(d, got);
      check("R8 kept data", d, exp_byte(1 + i / FB, i % FB));
    end
    check("R7 fill empty", int'(fill), 0);

    // refill across the top of memory and drain
    for (int k = 10; k < 10 + DEPTH / FB; k++) send_frame(k, 0);
    check("R6 fill after wrap refill", int'(fill), DEPTH);
    check("R8 overflow sticky", int'(overflow), 1);
    for (int i = 0; i < DEPTH; i++) begin
      read_byte(d, got);
      check("R6 wrapped data", d, exp_byte(10 + i / FB, i % FB));
    end

    check("R6 write addresses", wa_bad, 0);
    check("R4 write count", n_wr, FB * (1 + 2 * DEPTH / FB));
    check("R2 sclk phase width", sclk_viol, 0);
    check("R5 we_n low width", we_viol, 0);
    finish_up();
  end
endmodule